// File: doc/BRIEF.md
# PCI Bus Parity Error Checker and Reporter

This block sits beside a 32-bit PCI-style bus interface and checks even parity on every clock. The bus carries its parity bit one clock after the address/data and command/byte-enable lines it covers. The checker therefore keeps a copy of the earlier vector and compares it with the parity bit that arrives on the next clock. Errors in an address phase are reported on a system-error pin. Errors in a data phase are reported on a parity-error pin. Both pins are open-drain and are modelled as active-high drive-low enables.

Three sticky status bits record what was seen: detected parity error, signaled system error, and master data parity reported. Software clears them by writing ones through a status write strobe. Two bits of the command register control whether the pins are driven and whether the reported bit can set. The surrounding interface logic supplies the transaction role (bus master, or addressed target) and the four-bit command code of the current transaction.

Top module: `pci_parity_guard`

## Requirements
- R1: Parity is even across the 37 bits formed by `ad_i`, `cbe_n_i` and the `par_i` value sampled one clock later. An odd count of ones is an error.
- R2: An address-phase check is made only for the first clock in which `frame_n_i` is low after a clock in which it was high. Later clocks with `frame_n_i` still low never produce a system error.
- R3: Suppose an address-phase error starts at clock t. Then `serr_oe_o` is high for exactly clock t+2, and only if `cmd_reg_i[8]` was 1 on clock t+1.
- R4: An address-phase error sets `stat_o[14]` at clock t+2, whatever the value of `cmd_reg_i[8]`. The bit then stays set.
- R5: A data-phase check is made only on a clock where `irdy_n_i` and `trdy_n_i` are both low and `bus_cmd_i` is not the special-cycle code 4'b0001.
- R6: A data-phase check is made only while the device receives data. That means `is_target_i` is 1 with a write command (`bus_cmd_i[0]`=1), or `is_master_i` is 1 with a read command (`bus_cmd_i[0]`=0).
- R7: Suppose a qualified transfer at clock t has an error. Then `perr_oe_o` is high for exactly clock t+2, and only if `cmd_reg_i[6]` was 1 on clock t+1. Errors on back-to-back transfers give pulses on back-to-back clocks.
- R8: A data-phase error sets `stat_o[15]` at clock t+2, whatever the value of `cmd_reg_i[6]`.
- R9: `stat_o[8]` sets only on a data-phase error in a transfer where `is_master_i` was 1 and `cmd_reg_i[6]` was 1.
- R10: When `stat_wr_i` is 1, each status bit whose `stat_wdata_i` bit is 1 is cleared. Zero bits leave the status unchanged. A set in the same clock wins over the clear. All other `stat_o` bits read 0.
- R11: A synchronous active-low `rst_n` clears the status bits, both output enables and the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ad_i | input | 32 | Address/data lines |
| cbe_n_i | input | 4 | Command/byte-enable lines |
| par_i | input | 1 | Parity bit, valid one clock after the lines it covers |
| frame_n_i | input | 1 | Transaction frame, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| is_master_i | input | 1 | Device is the current bus master |
| is_target_i | input | 1 | Device is the addressed target |
| bus_cmd_i | input | 4 | Command code of the current transaction |
| cmd_reg_i | input | 16 | Command register (bit 8 system-error enable, bit 6 parity response enable) |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 16 | Status write data, one bit clears |
| stat_o | output | 16 | Status register (bits 15, 14, 8 live) |
| serr_oe_o | output | 1 | Drive system-error pin low |
| perr_oe_o | output | 1 | Drive parity-error pin low |

## Verification
The assertions check a set of cycle relations on every clock. Each error pulse must follow the enable bit sampled the clock before it. A parity-error pulse must trace back to a transfer two clocks earlier with both ready lines low. A system-error pulse must trace back to a frame that was low two clocks earlier. Every pulse must coincide with its sticky status bit, and the reported bit may only rise together with the detected bit. Whether the parity arithmetic is correct, and whether role, special-cycle and mid-frame gating are right, can only be shown by the bench. Its sweeps compare the pins and status against expected values it computes from bit counts and the role rules.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
   localparam int unsigned STAT_W      = 16;
   localparam int unsigned CMD_W       = 4;
   localparam logic [3:0]  CMD_SPECIAL = 4'b0001;
   // bit positions fixed by the configuration register layout
   localparam int unsigned STS_DET     = 15;
   localparam int unsigned STS_SIG     = 14;
   localparam int unsigned STS_DPR     = 8;
   localparam int unsigned CMD_SERR_EN = 8;
   localparam int unsigned CMD_PERR_EN = 6;
   localparam logic [STAT_W-1:0] STICKY_MASK =
      STAT_W'((1 << STS_DET) | (1 << STS_SIG) | (1 << STS_DPR));

   // device is the data receiver: target of a write or master of a read
   function automatic logic rx_side(input logic mst, input logic tgt,
                                    input logic [CMD_W-1:0] cmd);
      return (tgt && cmd[0]) || (mst && !cmd[0]);
   endfunction
endpackage

// File: rtl/pchk_lane.sv
module pchk_lane #(
   parameter int unsigned VEC_W      = 36,
   parameter bit          FOLD_EARLY = 1'b1,
   parameter int unsigned TAG_W      = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual_i,
   input  logic [VEC_W-1:0] vec_i,
   input  logic             par_i,
   input  logic [TAG_W-1:0] tag_i,
   output logic             err_o,
   output logic [TAG_W-1:0] tag_o
);
   logic             pend_q;
   logic [TAG_W-1:0] tag_q;
   logic             held_par;

   generate
      if (FOLD_EARLY) begin : g_fold
         logic par_q;
         always_ff @(posedge clk) begin
            if (!rst_n) par_q <= 1'b0;
            else        par_q <= ^vec_i;
         end
         assign held_par = par_q;
      end else begin : g_wide
         logic [VEC_W-1:0] vec_q;
         always_ff @(posedge clk) begin
            if (!rst_n) vec_q <= '0;
            else        vec_q <= vec_i;
         end
         assign held_par = ^vec_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tag_q  <= '0;
      end else begin
         pend_q <= qual_i;
         tag_q  <= tag_i;
      end
   end

   // even parity: folded vector plus late parity bit must xor to zero
   assign err_o = pend_q && (held_par ^ par_i);
   assign tag_o = tag_q;

   assert_err_after_qual_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(qual_i));
endmodule

// File: rtl/pchk_status.sv
module pchk_status
   import pchk_pkg::*;
#(
   parameter int unsigned             W    = STAT_W,
   parameter logic [STAT_W-1:0]       MASK = STICKY_MASK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] stat_o
);
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         if (MASK[b]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
               if (!rst_n) q <= 1'b0;
               else        q <= set_i[b] | (q & ~(wr_i & wdata_i[b]));
            end
            assign stat_o[b] = q;
            assert_set_wins_R10 : assert property (@(posedge clk) disable iff (!rst_n)
               set_i[b] |=> stat_o[b]);
         end else begin : g_zero
            assign stat_o[b] = 1'b0;
         end
      end
   endgenerate

   logic unused_in;
   assign unused_in = ^(set_i & ~MASK[W-1:0]);
endmodule

// File: rtl/pci_parity_guard.sv
module pci_parity_guard
   import pchk_pkg::*;
#(
   parameter int unsigned AD_W       = 32,
   parameter int unsigned BE_W       = 4,
   parameter bit          FOLD_EARLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AD_W-1:0]   ad_i,
   input  logic [BE_W-1:0]   cbe_n_i,
   input  logic              par_i,
   input  logic              frame_n_i,
   input  logic              irdy_n_i,
   input  logic              trdy_n_i,
   input  logic              is_master_i,
   input  logic              is_target_i,
   input  logic [CMD_W-1:0]  bus_cmd_i,
   input  logic [STAT_W-1:0] cmd_reg_i,
   input  logic              stat_wr_i,
   input  logic [STAT_W-1:0] stat_wdata_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              serr_oe_o,
   output logic              perr_oe_o
);
   localparam int unsigned VEC_W = AD_W + BE_W;

   generate
      if (AD_W % 8 != 0 || AD_W == 0) begin : g_bad_ad
         $error("AD_W must be a nonzero multiple of 8");
      end
      if (BE_W * 8 != AD_W) begin : g_bad_be
         $error("BE_W must give one enable per byte of AD_W");
      end
   endgenerate

   logic             frame_q;
   logic             addr_start, data_qual;
   logic             a_err, d_err;
   logic             d_mst;
   logic             unused_a_tag;
   logic             serr_q, perr_q;
   logic [STAT_W-1:0] set_vec;
   logic [VEC_W-1:0] bus_vec;

   assign bus_vec    = {ad_i, cbe_n_i};
   assign addr_start = !frame_n_i && frame_q;
   assign data_qual  = !irdy_n_i && !trdy_n_i && (bus_cmd_i != CMD_SPECIAL)
                       && rx_side(is_master_i, is_target_i, bus_cmd_i);

   always_ff @(posedge clk) begin
      if (!rst_n) frame_q <= 1'b1;
      else        frame_q <= frame_n_i;
   end

   pchk_lane #(.VEC_W(VEC_W), .FOLD_EARLY(FOLD_EARLY), .TAG_W(1)) u_addr_lane (
      .clk(clk), .rst_n(rst_n), .qual_i(addr_start), .vec_i(bus_vec),
      .par_i(par_i), .tag_i(1'b0), .err_o(a_err), .tag_o(unused_a_tag));

   pchk_lane #(.VEC_W(VEC_W), .FOLD_EARLY(FOLD_EARLY), .TAG_W(1)) u_data_lane (
      .clk(clk), .rst_n(rst_n), .qual_i(data_qual), .vec_i(bus_vec),
      .par_i(par_i), .tag_i(is_master_i), .err_o(d_err), .tag_o(d_mst));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         serr_q <= 1'b0;
         perr_q <= 1'b0;
      end else begin
         serr_q <= a_err && cmd_reg_i[CMD_SERR_EN];
         perr_q <= d_err && cmd_reg_i[CMD_PERR_EN];
      end
   end

   always_comb begin
      set_vec          = '0;
      set_vec[STS_SIG] = a_err;
      set_vec[STS_DET] = d_err;
      set_vec[STS_DPR] = d_err && d_mst && cmd_reg_i[CMD_PERR_EN];
   end

   pchk_status u_status (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .wr_i(stat_wr_i),
      .wdata_i(stat_wdata_i), .stat_o(stat_o));

   assign serr_oe_o = serr_q;
   assign perr_oe_o = perr_q;

   logic unused_cmd;
   assign unused_cmd = ^cmd_reg_i;

   assert_serr_from_frame_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> $past(!frame_n_i, 2));
   assert_serr_gated_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> $past(cmd_reg_i[CMD_SERR_EN]));
   assert_serr_one_clock_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |=> !serr_oe_o);
   assert_serr_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      serr_oe_o |-> stat_o[STS_SIG]);
   assert_perr_from_xfer_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      perr_oe_o |-> $past(!irdy_n_i && !trdy_n_i, 2));
   assert_perr_gated_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      perr_oe_o |-> $past(cmd_reg_i[CMD_PERR_EN]));
   assert_perr_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      perr_oe_o |-> stat_o[STS_DET]);
   assert_dpr_with_det_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_o[STS_DPR]) |-> stat_o[STS_DET]);
endmodule

// File: tb/pci_parity_guard_tb.sv
`timescale 1ns/1ps
module pci_parity_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] ad;
   logic [3:0]  cbe_n;
   logic        par, frame_n, irdy_n, trdy_n, mst, tgt, wr;
   logic [3:0]  bcmd;
   logic [15:0] creg, wdata, stat;
   logic        serr, perr;
   int          n_vec = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   pci_parity_guard u_dut (
      .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par),
      .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
      .is_master_i(mst), .is_target_i(tgt), .bus_cmd_i(bcmd),
      .cmd_reg_i(creg), .stat_wr_i(wr), .stat_wdata_i(wdata),
      .stat_o(stat), .serr_oe_o(serr), .perr_oe_o(perr));

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   task automatic idle();
      frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; ad = '0; cbe_n = '0;
      par = 1'b0; mst = 1'b0; tgt = 1'b0; bcmd = 4'b0110; wr = 1'b0; wdata = '0;
   endtask

   task automatic clear_all();
      @(negedge clk); wr = 1'b1; wdata = 16'hFFFF;
      @(negedge clk); wr = 1'b0; wdata = '0;
      chk("R10 clear", {16'h0, stat}, 32'h0);
   endtask

   function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
      return logic'($countones({a, c}) % 2);
   endfunction

   task automatic addr_run(input logic [31:0] a, input logic [3:0] c,
                           input logic bad, input logic en);
      @(negedge clk); frame_n = 1'b0; ad = a; cbe_n = c; creg = en ? 16'h0100 : 16'h0;
      @(negedge clk); par = even_par(a, c) ^ bad; ad = ~a; cbe_n = ~c;
      @(negedge clk); frame_n = 1'b1; par = 1'b0;
      chk("R1 R3 serr pulse", {31'h0, serr}, {31'h0, bad & en});
      chk("R4 sig sticky", {31'h0, stat[14]}, {31'h0, bad});
      chk("R9 dpr quiet on addr", {31'h0, stat[8]}, 32'h0);
      @(negedge clk);
      chk("R3 serr width", {31'h0, serr}, 32'h0);
      chk("R4 sig holds", {31'h0, stat[14]}, {31'h0, bad});
      clear_all();
   endtask

   task automatic data_run(input logic m, input logic t, input logic [3:0] cmd,
                           input logic [31:0] a, input logic [3:0] c,
                           input logic bad, input logic en);
      logic q;
      q = (cmd != 4'b0001) && ((t && cmd[0]) || (m && !cmd[0]));
      @(negedge clk); irdy_n = 1'b0; trdy_n = 1'b0; ad = a; cbe_n = c;
      mst = m; tgt = t; bcmd = cmd; creg = en ? 16'h0040 : 16'h0;
      @(negedge clk); irdy_n = 1'b1; trdy_n = 1'b1; par = even_par(a, c) ^ bad;
      @(negedge clk); par = 1'b0;
      chk("R5 R6 R7 perr pulse", {31'h0, perr}, {31'h0, q & bad & en});
      chk("R8 det sticky", {31'h0, stat[15]}, {31'h0, q & bad});
      chk("R9 dpr", {31'h0, stat[8]}, {31'h0, q & bad & en & m});
      chk("R3 serr quiet on data", {31'h0, serr}, 32'h0);
      @(negedge clk);
      chk("R7 perr width", {31'h0, perr}, 32'h0);
      clear_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      idle(); creg = '0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset status", {16'h0, stat}, 32'h0);
      chk("R11 reset pins", {30'h0, serr, perr}, 32'h0);

      // address sweep: R1 R3 R4
      for (int i = 0; i < 16; i++) begin
         for (int b = 0; b < 2; b++) begin
            for (int e = 0; e < 2; e++) begin
               addr_run(32'(i + 1) * 32'h9E3779B9, i[3:0], b[0], e[0]);
            end
         end
      end

      // R2: a mismatch on a later clock of the same frame is ignored
      creg = 16'h0100;
      @(negedge clk); frame_n = 1'b0; ad = 32'h0000_00F1; cbe_n = 4'h3;
      @(negedge clk); par = even_par(32'h0000_00F1, 4'h3); ad = 32'h0000_0001; cbe_n = 4'h0;
      @(negedge clk); par = ~even_par(32'h0000_0001, 4'h0); ad = '0;
      chk("R2 no serr mid frame a", {31'h0, serr}, 32'h0);
      @(negedge clk); frame_n = 1'b1; par = 1'b0;
      chk("R2 no serr mid frame b", {31'h0, serr}, 32'h0);
      chk("R2 no sig mid frame", {31'h0, stat[14]}, 32'h0);
      @(negedge clk);

      // data sweep: R5 R6 R7 R8 R9
      for (int r = 0; r < 3; r++) begin
         for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 2; b++) begin
               for (int e = 0; e < 2; e++) begin
                  logic [3:0] cm;
                  cm = (k == 0) ? 4'b0110 : (k == 1) ? 4'b0111 : (k == 2) ? 4'b0001 : 4'b1010;
                  data_run(r == 1, r == 2, cm, 32'h5A5A_0000 + 32'(r * 16 + k * 4 + b * 2 + e),
                           4'(k + r), b[0], e[0]);
               end
            end
         end
      end

      // R5: only initiator ready, bad parity, no check
      creg = 16'h0040; mst = 1'b1; bcmd = 4'b0110;
      @(negedge clk); irdy_n = 1'b0; trdy_n = 1'b1; ad = 32'h1; cbe_n = 4'h0;
      @(negedge clk); irdy_n = 1'b1; par = 1'b0;
      @(negedge clk);
      chk("R5 half handshake", {30'h0, perr, stat[15]}, 32'h0);

      // R7 back-to-back errors give adjacent pulses
      @(negedge clk); irdy_n = 1'b0; trdy_n = 1'b0; ad = 32'h3; cbe_n = 4'h0;
      @(negedge clk); par = 1'b1; ad = 32'h7; cbe_n = 4'h0;
      @(negedge clk); irdy_n = 1'b1; trdy_n = 1'b1; par = 1'b0;
      chk("R7 first pulse", {31'h0, perr}, 32'h1);
      @(negedge clk);
      chk("R7 second pulse", {31'h0, perr}, 32'h1);
      @(negedge clk);
      chk("R7 pulses end", {31'h0, perr}, 32'h0);
      clear_all();

      // R10 set wins over a same-clock clear
      @(negedge clk); irdy_n = 1'b0; trdy_n = 1'b0; ad = 32'h1; cbe_n = 4'h0;
      @(negedge clk); irdy_n = 1'b1; trdy_n = 1'b1; par = 1'b0; wr = 1'b1; wdata = 16'hFFFF;
      @(negedge clk); wr = 1'b0; wdata = '0;
      chk("R10 set wins", {16'h0, stat}, 32'h8100);
      @(negedge clk); wr = 1'b1; wdata = 16'h0000;
      @(negedge clk); wr = 1'b1; wdata = 16'h8000;
      chk("R10 zero write", {16'h0, stat}, 32'h8100);
      @(negedge clk); wr = 1'b0; wdata = '0;
      chk("R10 selective clear", {16'h0, stat}, 32'h0100);

      // R11 reset clears a set bit
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R11 reset mid run", {16'h0, stat}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 pins after reset", {30'h0, serr, perr}, 32'h0);
      report();
   end
endmodule